// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles the outcome of a conditional relative branch for an 8-bit processor whose program counter is 16 bits wide. The core presents the branch opcode byte, the signed displacement byte, the address at which the branch instruction starts, and the present carry, zero, negative and overflow flags. The block answers with whether the branch is taken, which address executes next, and how many clock cycles the branch costs in total.

A request is accepted when `req` is high and the block is not busy. One clock later the result appears with `resp_valid` high, and it stays on the outputs until the next accepted request. A taken branch costs extra cycles, and for those cycles the block raises `busy` and ignores any request. The core can use this to stretch its own sequencing. The block never writes the flags. It only reads them.

Top module: `br_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `resp_valid`, `taken`, `next_pc`, `cycles`, `invalid` and `busy` to zero.
- R2: An opcode is a branch only when its low five bits are `10000`. Bits 7:6 pick the flag under test: `00` negative, `01` overflow, `10` carry, `11` zero. Bit 5 set means the branch is taken when that flag is 1, and bit 5 clear means it is taken when the flag is 0.
- R3: A branch that is not taken gives `next_pc` = instruction address + 2 (modulo 2^16) and `cycles` = 2.
- R4: A taken branch gives `next_pc` = instruction address + 2 + the sign-extended displacement. The sum wraps modulo 2^16.
- R5: A taken branch costs 3 cycles when bits 15:8 of (instruction address + 2) equal bits 15:8 of the target. Otherwise it costs 4 cycles.
- R6: An opcode that is not a branch gives `taken` = 0, `next_pc` = address + 2, `cycles` = 2 and `invalid` = 1. For every branch opcode, `invalid` is 0.
- R7: `resp_valid` is high for exactly the one cycle after an accepted request. `taken`, `next_pc`, `cycles` and `invalid` hold their values until the next accepted request, even if the inputs change in between.
- R8: After an accepted request, `busy` is high for (`cycles` - 2) consecutive cycles, starting in the same cycle as `resp_valid`. A request seen while `busy` is high is ignored: no response follows it and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Asks for a branch to be resolved this cycle |
| opcode | input | 8 | Opcode byte of the instruction |
| disp | input | 8 | Signed relative displacement |
| inst_addr | input | 16 | Address of the first byte of the branch |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| resp_valid | output | 1 | Result of an accepted request is new this cycle |
| taken | output | 1 | Branch condition held |
| next_pc | output | 16 | Address of the next instruction to execute |
| cycles | output | 3 | Total cycle cost of the instruction (2, 3 or 4) |
| invalid | output | 1 | Opcode was not a conditional branch |
| busy | output | 1 | Extra branch cycles in progress; requests are ignored |

## Verification
The assertions assume that `rst_n` stays low for at least two clock edges, so that every output register holds a known value before any `$stable` or `|=>` check starts. They also assume that inputs change only away from the rising edge. The bench meets both assumptions: it holds reset for several cycles and drives every input on the falling edge. It also aims requests at busy cycles on purpose, because the ignore rule needs a stimulus that the block must not act on. The bench scrambles the inputs straight after each accepted request. This shows that the held results do not depend on anything sampled later.

// File: rtl/br_pkg.sv
// Package: shared encodings for the branch resolver.
// Assumes the opcode layout: low five bits 10000 mark a branch,
// bits 7:6 select the flag, bit 5 gives the required flag level.
package br_pkg;

    // Flag selector held in opcode bits 7:6
    typedef enum logic [1:0] {
        SEL_NEG   = 2'b00,
        SEL_OVF   = 2'b01,
        SEL_CARRY = 2'b10,
        SEL_ZERO  = 2'b11
    } flag_sel_e;

    localparam logic [4:0] BRANCH_LOW_BITS = 5'b10000;

    // Extra cycle cost beyond the base cost
    localparam int EXTRA_TAKEN = 1;
    localparam int EXTRA_CROSS = 2;

endpackage

// File: rtl/br_decode.sv
// Module: br_decode
// Decodes an opcode byte into a branch-valid indication, then evaluates
// the branch condition against the flag vector.
// Assumes OP_W >= 8. Flags arrive as separate bits and are read, never written.
module br_decode
    import br_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    input  logic            flag_c,
    input  logic            flag_z,
    input  logic            flag_n,
    input  logic            flag_v,
    output logic            is_branch,
    output logic            cond_met
);

    flag_sel_e sel;
    logic      want_set;
    logic      flag_val;

    // Classify the opcode and split out its selector fields
    always_comb begin
        is_branch = (opcode[4:0] == BRANCH_LOW_BITS);
        sel       = flag_sel_e'(opcode[7:6]);
        want_set  = opcode[5];
    end

    // Pick the flag under test
    always_comb begin
        unique case (sel)
            SEL_NEG:   flag_val = flag_n;
            SEL_OVF:   flag_val = flag_v;
            SEL_CARRY: flag_val = flag_c;
            SEL_ZERO:  flag_val = flag_z;
            default:   flag_val = 1'b0;
        endcase
    end

    // The condition holds when the flag level matches the wanted level
    always_comb begin
        cond_met = is_branch && (flag_val == want_set);
    end

    // R6: a non-branch opcode can never report its condition as met
    always_comb begin
        assert_nonbranch_cond_R6: assert (is_branch || !cond_met)
            else $error("condition met on non-branch opcode");
    end

    // Mark upper opcode bits as consumed when OP_W is wider than 8
    if (OP_W > 8) begin : g_wide_op
        logic unused_hi;
        always_comb unused_hi = ^opcode[OP_W-1:8];
    end

endmodule

// File: rtl/br_target.sv
// Module: br_target
// Computes the sequential address (instruction + its length), the branch
// target (sequential address + sign-extended displacement) and whether
// the target lies in another page than the sequential address.
// Assumes DISP_W <= PC_W and PAGE_W < PC_W. All sums wrap modulo 2^PC_W.
module br_target #(
    parameter int PC_W      = 16,
    parameter int DISP_W    = 8,
    parameter int PAGE_W    = 8,
    parameter int INSTR_LEN = 2
) (
    input  logic [PC_W-1:0]   inst_addr,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   seq_pc,
    output logic [PC_W-1:0]   tgt_pc,
    output logic              page_cross
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    // Sign-extend the displacement to the address width
    if (EXT_W > 0) begin : g_ext
        always_comb disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_noext
        always_comb disp_ext = disp[PC_W-1:0];
    end

    // Form the fall-through and target addresses
    always_comb begin
        seq_pc = inst_addr + PC_W'(INSTR_LEN);
        tgt_pc = seq_pc + disp_ext;
    end

    // Compare the page numbers of fall-through and target
    always_comb begin
        page_cross = (seq_pc[PC_W-1:PAGE_W] != tgt_pc[PC_W-1:PAGE_W]);
    end

endmodule

// File: rtl/br_cost.sv
// Module: br_cost
// Turns the outcome (taken, page crossing) into a total cycle count and
// the number of extra cycles beyond the base cost.
// Assumes CYC_W is wide enough to hold BASE_CYC + 2.
module br_cost
    import br_pkg::*;
#(
    parameter int CYC_W    = 3,
    parameter int BASE_CYC = 2
) (
    input  logic             taken,
    input  logic             page_cross,
    output logic [CYC_W-1:0] total,
    output logic [CYC_W-1:0] extra
);

    // Extra cycles: none if not taken, one more again on a page change
    always_comb begin
        if (!taken)          extra = '0;
        else if (page_cross) extra = CYC_W'(EXTRA_CROSS);
        else                 extra = CYC_W'(EXTRA_TAKEN);
        total = CYC_W'(BASE_CYC) + extra;
    end

endmodule

// File: rtl/br_seq.sv
// Module: br_seq
// Holds busy for a loaded number of cycles after each accepted request.
// Assumes load only arrives while not busy; the top gates it.
module br_seq #(
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] extra,
    output logic             busy
);

    logic [CYC_W-1:0] remain;

    // Load the extra-cycle count, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (load)           remain <= extra;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    // Busy while cycles remain
    always_comb busy = (remain != '0);

    // R8: the countdown only moves downwards between loads
    assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (remain == $past(remain) - 1'b1))
        else $error("busy countdown skipped");

endmodule

// File: rtl/br_resolver.sv
// Module: br_resolver (top)
// Resolves one conditional relative branch per accepted request: decodes
// the opcode, evaluates the flag, forms the next PC and the cycle cost,
// and registers the result. Busy covers the extra cycles of a taken branch.
// Assumes requests are single-cycle pulses sampled at the rising edge.
module br_resolver #(
    parameter int OP_W      = 8,
    parameter int PC_W      = 16,
    parameter int DISP_W    = 8,
    parameter int PAGE_W    = 8,
    parameter int INSTR_LEN = 2,
    parameter int BASE_CYC  = 2,
    parameter int CYC_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   inst_addr,
    input  logic              flag_c,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_v,
    output logic              resp_valid,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic [CYC_W-1:0]  cycles,
    output logic              invalid,
    output logic              busy
);

    logic             is_branch;
    logic             cond_met;
    logic [PC_W-1:0]  seq_pc;
    logic [PC_W-1:0]  tgt_pc;
    logic             page_cross;
    logic [CYC_W-1:0] cyc_total;
    logic [CYC_W-1:0] cyc_extra;
    logic             accept;
    logic [PC_W-1:0]  pc_sel;

    br_decode #(.OP_W(OP_W)) u_decode (
        .opcode    (opcode),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .is_branch (is_branch),
        .cond_met  (cond_met)
    );

    br_target #(
        .PC_W(PC_W), .DISP_W(DISP_W), .PAGE_W(PAGE_W), .INSTR_LEN(INSTR_LEN)
    ) u_target (
        .inst_addr  (inst_addr),
        .disp       (disp),
        .seq_pc     (seq_pc),
        .tgt_pc     (tgt_pc),
        .page_cross (page_cross)
    );

    br_cost #(.CYC_W(CYC_W), .BASE_CYC(BASE_CYC)) u_cost (
        .taken      (cond_met),
        .page_cross (page_cross),
        .total      (cyc_total),
        .extra      (cyc_extra)
    );

    br_seq #(.CYC_W(CYC_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .extra (cyc_extra),
        .busy  (busy)
    );

    // Accept a request only when no extra cycles are pending
    always_comb accept = req && !busy;

    // Choose target or fall-through address
    always_comb pc_sel = cond_met ? tgt_pc : seq_pc;

    // Pulse resp_valid for one cycle after each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) resp_valid <= 1'b0;
        else        resp_valid <= accept;
    end

    // Capture the result on accept and hold it until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            next_pc <= '0;
            cycles  <= '0;
            invalid <= 1'b0;
        end else if (accept) begin
            taken   <= cond_met;
            next_pc <= pc_sel;
            cycles  <= cyc_total;
            invalid <= !is_branch;
        end
    end

    // R6: an invalid result is never taken and costs the base cycles
    assert_invalid_plain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && invalid) |-> (!taken && cycles == CYC_W'(BASE_CYC)))
        else $error("invalid opcode produced a taken or costly result");

    // R5: cost is base when not taken, base+1 or base+2 when taken
    assert_cost_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (taken ? (cycles == CYC_W'(BASE_CYC + 1) ||
                                 cycles == CYC_W'(BASE_CYC + 2))
                              : (cycles == CYC_W'(BASE_CYC))))
        else $error("cycle cost out of range");

    // R8: a request during busy produces no response
    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !resp_valid)
        else $error("response after request during busy");

    // R8: busy in the response cycle exactly when extra cycles exist
    assert_busy_matches_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (busy == (cycles > CYC_W'(BASE_CYC))))
        else $error("busy disagrees with cycle cost");

    // R7: results stay put between responses
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> ($stable(next_pc) && $stable(taken) &&
                         $stable(cycles) && $stable(invalid)))
        else $error("result changed without a response");

endmodule

// File: tb/tb_br_resolver.sv
// Scoreboard bench for br_resolver: the driver queues expected results
// computed from the requirements, the monitor pops and compares them.
module tb_br_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic [15:0] inst_addr = '0;
    logic        flag_c = 1'b0, flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
    logic        resp_valid, taken, invalid, busy;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic        tk;
        logic [15:0] pc;
        logic [2:0]  cy;
        logic        inv;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   busy_left = 0;
    bit   mon_on = 1'b0;
    exp_t last;

    always #4 clk = ~clk; // 125 MHz

    br_resolver dut (
        .clk(clk), .rst_n(rst_n), .req(req), .opcode(opcode), .disp(disp),
        .inst_addr(inst_addr), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v), .resp_valid(resp_valid),
        .taken(taken), .next_pc(next_pc), .cycles(cycles),
        .invalid(invalid), .busy(busy)
    );

    // Reference model built from R2..R6
    function automatic exp_t model(input logic [7:0] op, input logic [7:0] d,
                                   input logic [15:0] a, input logic c,
                                   input logic z, input logic n, input logic v);
        exp_t e;
        logic [15:0] seq, tgt;
        logic f;
        logic br;
        br  = (op[4:0] == 5'b10000);
        seq = a + 16'd2;
        tgt = seq + {{8{d[7]}}, d};
        case (op[7:6])
            2'b00: f = n;
            2'b01: f = v;
            2'b10: f = c;
            default: f = z;
        endcase
        e.tk  = br && (f == op[5]);
        e.inv = !br;
        e.pc  = e.tk ? tgt : seq;
        e.cy  = !e.tk ? 3'd2 : ((seq[15:8] != tgt[15:8]) ? 3'd4 : 3'd3);
        e.tag = !br ? "R6" : (e.tk ? ((e.cy == 3'd4) ? "R5" : "R4") : "R3");
        return e;
    endfunction

    // Driver: wait until free, pulse req, queue the expected result, scramble inputs (R7)
    task automatic send(input logic [7:0] op, input logic [7:0] d,
                        input logic [15:0] a, input logic c, input logic z,
                        input logic n, input logic v);
        @(negedge clk);
        while (busy) @(negedge clk);
        opcode = op; disp = d; inst_addr = a;
        flag_c = c; flag_z = z; flag_n = n; flag_v = v;
        req = 1'b1;
        exp_q.push_back(model(op, d, a, c, z, n, v));
        @(negedge clk);
        req = 1'b0;
        opcode = ~op; disp = ~d; inst_addr = ~a;
        flag_c = ~c; flag_z = ~z; flag_n = ~n; flag_v = ~v;
    endtask

    // Monitor: compare each response and track busy length (R7, R8)
    always @(negedge clk) begin
        if (mon_on) begin
            if (resp_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fails++;
                    $display("FAIL R7: resp_valid=1 with no request pending (exp 0)");
                end else begin
                    last = exp_q.pop_front();
                    if (taken !== last.tk || next_pc !== last.pc ||
                        cycles !== last.cy || invalid !== last.inv) begin
                        n_fails++;
                        $display("FAIL %s: got tk=%0b pc=%h cy=%0d inv=%0b exp tk=%0b pc=%h cy=%0d inv=%0b",
                                 last.tag, taken, next_pc, cycles, invalid,
                                 last.tk, last.pc, last.cy, last.inv);
                    end
                    busy_left = int'(last.cy) - 2;
                end
            end else if (busy_left > 0) begin
                busy_left--;
            end
            if (busy !== (busy_left > 0)) begin
                n_checks++;
                n_fails++;
                $display("FAIL R8: busy=%0b exp %0b", busy, busy_left > 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish (exp completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        n_checks++;
        if (resp_valid !== 0 || taken !== 0 || next_pc !== 0 || cycles !== 0 ||
            invalid !== 0 || busy !== 0) begin
            n_fails++;
            $display("FAIL R1: rv=%0b tk=%0b pc=%h cy=%0d inv=%0b bsy=%0b exp all 0",
                     resp_valid, taken, next_pc, cycles, invalid, busy);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: every branch opcode with its flag at both levels, other flags opposite
        for (int k = 0; k < 8; k++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                logic [7:0] op;
                logic [3:0] fl;
                op = {k[2:1], k[0], 5'b10000};
                fl = lvl[0] ? 4'b0000 : 4'b1111;
                case (k[2:1])
                    2'b00: fl[2] = lvl[0];
                    2'b01: fl[3] = lvl[0];
                    2'b10: fl[0] = lvl[0];
                    default: fl[1] = lvl[0];
                endcase
                send(op, 8'h10, 16'h4020, fl[0], fl[1], fl[2], fl[3]);
            end
        end

        // R5: forward page crossing, backward page crossing, same page backward
        send(8'hB0, 8'h7F, 16'h12F0, 1, 0, 0, 0);
        send(8'hB0, 8'h80, 16'h1200, 1, 0, 0, 0);
        send(8'hB0, 8'hFE, 16'h1280, 1, 0, 0, 0);
        // R5: fall-through already in next page; target equal or one before
        send(8'hF0, 8'h00, 16'h12FE, 0, 1, 0, 0);
        send(8'hF0, 8'hFF, 16'h12FE, 0, 1, 0, 0);
        // R4: wrap at the top of the address space
        send(8'h10, 8'h05, 16'hFFFE, 0, 0, 0, 0);
        send(8'h10, 8'h20, 16'hFFF0, 0, 0, 0, 0);
        // R3: not taken near a page edge and at wrap
        send(8'h90, 8'h40, 16'h00FF, 1, 0, 0, 0);
        send(8'h70, 8'h40, 16'hFFFF, 0, 0, 0, 0);
        // R6: non-branch opcodes
        send(8'hEA, 8'h22, 16'h3000, 1, 1, 1, 1);
        send(8'h00, 8'h22, 16'h3000, 0, 0, 0, 0);
        send(8'h91, 8'h22, 16'h3000, 0, 0, 0, 0);
        send(8'hB1, 8'h22, 16'hFFFF, 1, 1, 1, 1);

        // R8: a request during busy is ignored and the outputs hold
        send(8'hD0, 8'h7F, 16'h20F0, 0, 0, 0, 0);
        // now at the negedge after the accepting edge: busy is high
        opcode = 8'h30; disp = 8'h01; inst_addr = 16'h0100; flag_n = 1'b1;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        n_checks++;
        if (resp_valid !== 1'b0 || next_pc !== 16'h2171 || cycles !== 3'd4) begin
            n_fails++;
            $display("FAIL R8: rv=%0b pc=%h cy=%0d exp rv=0 pc=2171 cy=4",
                     resp_valid, next_pc, cycles);
        end
        // after busy clears a new request is served
        send(8'h50, 8'h03, 16'h0500, 0, 0, 0, 0);

        repeat (6) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fails++;
            $display("FAIL R7: %0d responses missing (exp 0)", exp_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule